// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block collects interrupt requests from a set of shared peripheral lines and from per-processor local sources, holds their pending state, and presents to each processor port the single most urgent request that is enabled and routed to that processor. Software configures it through a 32-bit word-addressed register port. Through that port it enables or disables each source, picks edge or level triggering, assigns an 8-bit priority and, for shared lines, a set of target processors. It also clears latched edges and raises software interrupts aimed at a list of processors.

The first 32 source numbers are local to each processor. Numbers 0 to 15 are software interrupts and numbers 16 to 31 are private peripheral lines, one bundle per processor. For these sources the enable and pending bits exist once per processor, and the `cpu_id` input selects which copy a register access reaches. Source numbers from 32 upward are shared lines. A global forwarding bit gates every processor output. Each processor output is registered and carries a valid flag, the winning source number and its priority.

Top module: `irq_distributor`

## Requirements
- R1: In the set-enable word, a 1 bit enables its source. In the clear-enable word, a 1 bit disables its source. A 0 bit in either word changes nothing. A read of either word returns the current enable bits.
- R2: Enable words hold 32 sources each. Source n is in bit n%32 of set-enable word address 8+n/32 and of clear-enable word address 12+n/32. The pending word (address 16+n/32, same bit) reads the pending state.
- R3: Trigger configuration is at word address 24+n/16 and uses two bits per source. Bit 2*(n%16)+1 is 1 for rising edge and 0 for level-high. Bit 2*(n%16) reads 0. The fields of sources 0 to 15 always read binary 10 and ignore writes.
- R4: An edge source becomes pending when its input rises. It stays pending after the input falls, until a 1 is written to its bit in the pending word. That write clears it.
- R5: A level source is pending exactly while its input is high. A write to its pending bit has no effect on it.
- R6: The priority byte of source n is bits 8*(n%4)+7:8*(n%4) of word address 32+n/4. Among candidate sources, a lower priority value wins, and when priorities are equal the lower source number wins. The output carries the winner's number and priority.
- R7: The target byte of a shared source is at word address 64+n/4, byte n%4. Bit c of that byte routes the source to processor c. Local sources go only to their own processor. Their target bytes read as the accessing processor's one-hot bit and ignore writes.
- R8: For sources 0 to 31, each processor has its own enable and pending bits, and `cpu_id` selects the copy that a register access reads or writes.
- R9: The read-only type word at address 1 returns (N/32)-1 in bits 4:0 and zero in its other bits, where N is the total number of sources. Writes to it are ignored.
- R10: A write to address 2 sets software interrupt wdata[3:0] pending in the local state of every processor c whose bit 16+c of wdata is 1.
- R11: While bit 0 of the control word at address 0 is 0, every `irq_valid` bit is 0. While it is 1, requests are forwarded. The control word resets to 0.
- R12: Register writes take effect at the clock edge on which `wr_en` is high. `rdata` returns, one edge later, the word at the address presented. A processor output reflects an input level two edges after that level is applied, and reflects a register write one edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_id | input | CPU_W | Processor whose local bank a register access reaches |
| addr | input | 7 | Word address of the register access |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the previous cycle's address |
| spi_in | input | NUM_SPI | Shared peripheral request lines (source 32+i) |
| ppi_in | input | NUM_CPU*16 | Private lines, bits c*16+k drive source 16+k of processor c |
| irq_valid | output | NUM_CPU | A request is forwarded to processor c |
| irq_id | output | NUM_CPU*ID_W | Winning source number per processor |
| irq_prio | output | NUM_CPU*8 | Priority of the winning source per processor |

## Verification
The bench targets the arbitration corners. In a priority tie the lower source number must win, so a comparator written as less-or-equal would pick the higher one. An edge-triggered source must survive its input falling and must vanish only after a clear-pending write. A design that treated edge sources as level would drop the request early. The banked enables, and software interrupts aimed at only one processor, must not leak into the other processor's view, which catches an index that ignores `cpu_id`. The bench also checks that the configuration of software-interrupt sources stays fixed and that the target bytes of local sources cannot be written, and it checks that clearing the forwarding bit silences every output without losing the pending state underneath.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int ADDR_W  = 7;
  localparam int LOC_N   = 32;
  localparam int SGI_N   = 16;
  localparam int A_CTRL  = 0;
  localparam int A_TYPE  = 1;
  localparam int A_SGI   = 2;
  localparam int A_SETEN = 8;
  localparam int A_CLREN = 12;
  localparam int A_PEND  = 16;
  localparam int A_CFG   = 24;
  localparam int A_PRIO  = 32;
  localparam int A_TGT   = 64;

  function automatic logic [ADDR_W-1:0] wa(input int base, input int off);
    return ADDR_W'(base + off);
  endfunction
endpackage

// File: rtl/irqd_src.sv
module irqd_src (
  input  logic clk,
  input  logic rst,
  input  logic lvl_in,
  input  logic edge_mode,
  input  logic clr,
  output logic pend
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      prev_q <= lvl_in;
      if (!edge_mode)
        pend <= lvl_in;
      else if (lvl_in && !prev_q)
        pend <= 1'b1;
      else if (clr)
        pend <= 1'b0;
    end
  end
endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter #(
  parameter int N    = 96,
  parameter int ID_W = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fwd_en,
  input  logic [N-1:0]        cand,
  input  logic [N-1:0][7:0]   prio,
  output logic                irq_valid,
  output logic [ID_W-1:0]     irq_id,
  output logic [7:0]          irq_prio
);
  logic            found;
  logic [7:0]      best_p;
  logic [ID_W-1:0] best_id;

  always_comb begin
    found   = 1'b0;
    best_p  = 8'hFF;
    best_id = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || prio[i] < best_p)) begin
        found   = 1'b1;
        best_p  = prio[i];
        best_id = ID_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid <= 1'b0;
      irq_id    <= '0;
      irq_prio  <= '0;
    end else begin
      irq_valid <= fwd_en && found;
      irq_id    <= (fwd_en && found) ? best_id : '0;
      irq_prio  <= (fwd_en && found) ? best_p  : '0;
    end
  end
endmodule

// File: rtl/irqd_regs.sv
module irqd_regs
  import irqd_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_SPI = 64,
  localparam int N      = LOC_N + NUM_SPI,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [CPU_W-1:0]              cpu_id,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          wr_en,
  input  logic [31:0]                   wdata,
  output logic [31:0]                   rdata,
  output logic                          fwd_en,
  output logic [NUM_CPU-1:0][31:0]      en_loc,
  output logic [NUM_SPI-1:0]            en_spi,
  output logic [15:0]                   edge_loc,
  output logic [NUM_SPI-1:0]            edge_spi,
  output logic [N-1:0][7:0]             prio,
  output logic [NUM_SPI-1:0][NUM_CPU-1:0] tgt,
  input  logic [NUM_CPU-1:0][31:0]      pend_loc,
  input  logic [NUM_SPI-1:0]            pend_spi,
  output logic [NUM_CPU-1:0][31:0]      clr_loc,
  output logic [NUM_SPI-1:0]            clr_spi,
  output logic [NUM_CPU-1:0][15:0]      sgi_set
);
  localparam logic [4:0] TYPE_VAL = 5'(N / 32 - 1);

  logic [31:0] rd_next;

  // Storage updates
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_en   <= 1'b0;
      en_loc   <= '0;
      en_spi   <= '0;
      edge_loc <= '0;
      edge_spi <= '0;
      prio     <= '0;
      tgt      <= '0;
    end else if (wr_en) begin
      if (addr == wa(A_CTRL, 0)) fwd_en <= wdata[0];
      for (int c = 0; c < NUM_CPU; c++) begin
        if (cpu_id == CPU_W'(c)) begin
          if (addr == wa(A_SETEN, 0))
            en_loc[c] <= en_loc[c] | wdata;
          else if (addr == wa(A_CLREN, 0))
            en_loc[c] <= en_loc[c] & ~wdata;
        end
      end
      for (int k = 0; k < 16; k++)
        if (addr == wa(A_CFG, 1)) edge_loc[k] <= wdata[2*k+1];
      for (int s = 0; s < NUM_SPI; s++) begin
        if (addr == wa(A_SETEN, (s+32)/32) && wdata[(s+32)%32]) en_spi[s] <= 1'b1;
        if (addr == wa(A_CLREN, (s+32)/32) && wdata[(s+32)%32]) en_spi[s] <= 1'b0;
        if (addr == wa(A_CFG, (s+32)/16)) edge_spi[s] <= wdata[2*((s+32)%16)+1];
        if (addr == wa(A_TGT, (s+32)/4)) tgt[s] <= wdata[8*((s+32)%4) +: NUM_CPU];
      end
      for (int i = 0; i < N; i++)
        if (addr == wa(A_PRIO, i/4)) prio[i] <= wdata[8*(i%4) +: 8];
    end
  end

  // Write-side pulses toward the pending logic
  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      clr_loc[c] = (wr_en && addr == wa(A_PEND, 0) && cpu_id == CPU_W'(c)) ? wdata : 32'h0;
      sgi_set[c] = (wr_en && addr == wa(A_SGI, 0) && wdata[16+c]) ? (16'h1 << wdata[3:0]) : 16'h0;
    end
    for (int s = 0; s < NUM_SPI; s++)
      clr_spi[s] = wr_en && addr == wa(A_PEND, (s+32)/32) && wdata[(s+32)%32];
  end

  // Read mux
  always_comb begin
    rd_next = 32'h0;
    if (addr == wa(A_CTRL, 0)) rd_next[0] = fwd_en;
    if (addr == wa(A_TYPE, 0)) rd_next[4:0] = TYPE_VAL;
    if (addr == wa(A_CFG, 0)) rd_next = 32'hAAAA_AAAA;
    for (int k = 0; k < 16; k++)
      if (addr == wa(A_CFG, 1)) rd_next[2*k+1] = edge_loc[k];
    for (int c = 0; c < NUM_CPU; c++) begin
      if (cpu_id == CPU_W'(c)) begin
        if (addr == wa(A_SETEN, 0) || addr == wa(A_CLREN, 0)) rd_next = en_loc[c];
        if (addr == wa(A_PEND, 0)) rd_next = pend_loc[c];
        for (int w = 0; w < LOC_N/4; w++)
          if (addr == wa(A_TGT, w)) rd_next = {4{8'(1 << c)}};
      end
    end
    for (int s = 0; s < NUM_SPI; s++) begin
      if (addr == wa(A_SETEN, (s+32)/32) || addr == wa(A_CLREN, (s+32)/32))
        rd_next[(s+32)%32] = en_spi[s];
      if (addr == wa(A_PEND, (s+32)/32)) rd_next[(s+32)%32] = pend_spi[s];
      if (addr == wa(A_CFG, (s+32)/16)) rd_next[2*((s+32)%16)+1] = edge_spi[s];
      if (addr == wa(A_TGT, (s+32)/4)) rd_next[8*((s+32)%4) +: NUM_CPU] = tgt[s];
    end
    for (int i = 0; i < N; i++)
      if (addr == wa(A_PRIO, i/4)) rd_next[8*(i%4) +: 8] = prio[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= 32'h0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irqd_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_SPI = 64,
  localparam int N      = LOC_N + NUM_SPI,
  localparam int ID_W   = $clog2(N),
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CPU_W-1:0]        cpu_id,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr_en,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  input  logic [NUM_SPI-1:0]      spi_in,
  input  logic [NUM_CPU*16-1:0]   ppi_in,
  output logic [NUM_CPU-1:0]      irq_valid,
  output logic [NUM_CPU*ID_W-1:0] irq_id,
  output logic [NUM_CPU*8-1:0]    irq_prio
);
  logic                           fwd_en;
  logic [NUM_CPU-1:0][31:0]       en_loc;
  logic [NUM_SPI-1:0]             en_spi;
  logic [15:0]                    edge_loc;
  logic [NUM_SPI-1:0]             edge_spi;
  logic [N-1:0][7:0]              prio;
  logic [NUM_SPI-1:0][NUM_CPU-1:0] tgt;
  logic [NUM_CPU-1:0][31:0]       pend_loc;
  logic [NUM_SPI-1:0]             pend_spi;
  logic [NUM_CPU-1:0][31:0]       clr_loc;
  logic [NUM_SPI-1:0]             clr_spi;
  logic [NUM_CPU-1:0][15:0]       sgi_set;
  logic [NUM_CPU-1:0][15:0]       sgi_pend;
  logic [NUM_CPU-1:0][15:0]       ppi_pend;
  logic [NUM_CPU-1:0][N-1:0]      cand;

  irqd_regs #(.NUM_CPU(NUM_CPU), .NUM_SPI(NUM_SPI)) u_regs (
    .clk, .rst, .cpu_id, .addr, .wr_en, .wdata, .rdata,
    .fwd_en, .en_loc, .en_spi, .edge_loc, .edge_spi, .prio, .tgt,
    .pend_loc, .pend_spi, .clr_loc, .clr_spi, .sgi_set
  );

  for (genvar s = 0; s < NUM_SPI; s++) begin : g_spi
    irqd_src u_src (
      .clk, .rst, .lvl_in(spi_in[s]), .edge_mode(edge_spi[s]),
      .clr(clr_spi[s]), .pend(pend_spi[s])
    );
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (rst) sgi_pend[c] <= '0;
      else     sgi_pend[c] <= (sgi_pend[c] & ~clr_loc[c][15:0]) | sgi_set[c];
    end

    for (genvar k = 0; k < 16; k++) begin : g_ppi
      irqd_src u_src (
        .clk, .rst, .lvl_in(ppi_in[c*16+k]), .edge_mode(edge_loc[k]),
        .clr(clr_loc[c][16+k]), .pend(ppi_pend[c][k])
      );
    end

    assign pend_loc[c] = {ppi_pend[c], sgi_pend[c]};

    always_comb begin
      cand[c][LOC_N-1:0] = pend_loc[c] & en_loc[c];
      for (int s = 0; s < NUM_SPI; s++)
        cand[c][LOC_N+s] = pend_spi[s] && en_spi[s] && tgt[s][c];
    end

    irqd_arbiter #(.N(N), .ID_W(ID_W)) u_arb (
      .clk, .rst, .fwd_en, .cand(cand[c]), .prio,
      .irq_valid(irq_valid[c]),
      .irq_id(irq_id[c*ID_W +: ID_W]),
      .irq_prio(irq_prio[c*8 +: 8])
    );
  end
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker
  import irqd_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_SPI = 64,
  localparam int N      = LOC_N + NUM_SPI,
  localparam int ID_W   = $clog2(N)
) (
  input logic                     clk,
  input logic                     rst,
  input logic [ADDR_W-1:0]        addr,
  input logic                     wr_en,
  input logic [31:0]              wdata,
  input logic [31:0]              rdata,
  input logic                     fwd_en,
  input logic [NUM_SPI-1:0]       en_spi,
  input logic [NUM_CPU-1:0][31:0] pend_loc,
  input logic [NUM_CPU-1:0]       irq_valid,
  input logic [NUM_CPU*ID_W-1:0]  irq_id
);
  assert_fwd_off_R11: assert property (@(posedge clk) disable iff (rst)
    !fwd_en |=> (irq_valid == '0));

  assert_type_R9: assert property (@(posedge clk) disable iff (rst)
    (addr == wa(A_TYPE, 0)) |=> (rdata == 32'(N/32 - 1)));

  assert_clr_en_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == wa(A_CLREN, 1) && wdata[0]) |=> !en_spi[0]);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    assert_id_range_R6: assert property (@(posedge clk) disable iff (rst)
      irq_valid[c] |-> (int'(irq_id[c*ID_W +: ID_W]) < N));

    assert_sgi_R10: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == wa(A_SGI, 0) && wdata[16+c]) |=> pend_loc[c][$past(wdata[3:0])]);
  end
endmodule

bind irq_distributor irqd_checker #(.NUM_CPU(NUM_CPU), .NUM_SPI(NUM_SPI)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
  .fwd_en(fwd_en), .en_spi(en_spi), .pend_loc(pend_loc),
  .irq_valid(irq_valid), .irq_id(irq_id)
);

// File: tb/irq_distributor_test.sv
module irq_distributor_test;
  localparam int NUM_CPU = 2;
  localparam int NUM_SPI = 64;
  localparam int ID_W    = 7;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [0:0]              cpu_id = '0;
  logic [6:0]              addr = '0;
  logic                    wr_en = 1'b0;
  logic [31:0]             wdata = '0;
  logic [31:0]             rdata;
  logic [NUM_SPI-1:0]      spi_in = '0;
  logic [NUM_CPU*16-1:0]   ppi_in = '0;
  logic [NUM_CPU-1:0]      irq_valid;
  logic [NUM_CPU*ID_W-1:0] irq_id;
  logic [NUM_CPU*8-1:0]    irq_prio;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  irq_distributor #(.NUM_CPU(NUM_CPU), .NUM_SPI(NUM_SPI)) uut (
    .clk, .rst, .cpu_id, .addr, .wr_en, .wdata, .rdata,
    .spi_in, .ppi_in, .irq_valid, .irq_id, .irq_prio
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    @(negedge clk);
    d = rdata;
  endtask

  function automatic logic [31:0] id_of(input int c);
    return 32'(irq_id[c*ID_W +: ID_W]);
  endfunction

  task automatic test_reset();
    logic [31:0] v;
    chk("R11 reset valid", 32'(irq_valid), 0);
    rd(7'd0, v);  chk("R11 reset ctrl", v, 0);
    rd(7'd9, v);  chk("R1 reset enables", v, 0);
    rd(7'd40, v); chk("R6 reset prio", v, 0);
  endtask

  task automatic test_type();
    logic [31:0] v;
    rd(7'd1, v); chk("R9 type", v, 32'd2);
    wr(7'd1, 32'hFFFF_FFFF);
    rd(7'd1, v); chk("R9 type after write", v, 32'd2);
  endtask

  task automatic test_enable();
    logic [31:0] v;
    cpu_id = 0;
    wr(7'd9, 32'h5);
    rd(7'd9, v);  chk("R1 set alias read", v, 32'h5);
    rd(7'd13, v); chk("R2 clear alias read", v, 32'h5);
    wr(7'd13, 32'h4);
    rd(7'd9, v);  chk("R1 clear one bit", v, 32'h1);
    wr(7'd9, 32'h0);
    wr(7'd13, 32'h0);
    rd(7'd13, v); chk("R1 zero bits no effect", v, 32'h1);
  endtask

  task automatic test_config();
    logic [31:0] v;
    wr(7'd26, 32'hFFFF_FFFF);
    rd(7'd26, v); chk("R3 cfg upper bits only", v, 32'hAAAA_AAAA);
    wr(7'd26, 32'h0);
    rd(7'd26, v); chk("R3 cfg cleared", v, 32'h0);
    wr(7'd24, 32'h0);
    rd(7'd24, v); chk("R3 sgi cfg fixed", v, 32'hAAAA_AAAA);
  endtask

  task automatic test_level();
    logic [31:0] v;
    wr(7'd72, 32'h0000_0001);
    wr(7'd0, 32'h1);
    @(negedge clk); spi_in[0] = 1'b1;
    tick(1); chk("R12 one edge not yet", 32'(irq_valid[0]), 0);
    tick(1); chk("R5 level pending valid", 32'(irq_valid[0]), 1);
    chk("R5 level id", id_of(0), 32);
    wr(7'd17, 32'h1);
    tick(1); chk("R5 clear ignored on level", 32'(irq_valid[0]), 1);
    rd(7'd17, v); chk("R2 pending read", v, 32'h1);
    spi_in[0] = 1'b0;
    tick(2); chk("R5 level drops", 32'(irq_valid[0]), 0);
  endtask

  task automatic test_edge();
    logic [31:0] v;
    wr(7'd26, 32'h2);
    @(negedge clk); spi_in[0] = 1'b1;
    @(negedge clk); spi_in[0] = 1'b0;
    tick(1); chk("R4 edge latched", 32'(irq_valid[0]), 1);
    tick(4); chk("R4 edge held", 32'(irq_valid[0]), 1);
    chk("R4 edge id", id_of(0), 32);
    wr(7'd17, 32'h1);
    tick(1); chk("R4 cleared", 32'(irq_valid[0]), 0);
    rd(7'd17, v); chk("R4 pending read after clear", v, 0);
  endtask

  task automatic test_priority();
    logic [31:0] v;
    wr(7'd9, 32'h6);
    wr(7'd72, 32'h0001_0101);
    wr(7'd40, 32'h0020_4080);
    rd(7'd40, v); chk("R6 prio readback", v, 32'h0020_4080);
    @(negedge clk); spi_in[1] = 1'b1; spi_in[2] = 1'b1;
    tick(2);
    chk("R6 lower value wins", id_of(0), 34);
    chk("R6 winner prio", 32'(irq_prio[7:0]), 32'h20);
    wr(7'd40, 32'h0020_2080);
    tick(1);
    chk("R6 tie lower id", id_of(0), 33);
  endtask

  task automatic test_target();
    logic [31:0] v;
    wr(7'd72, 32'h0002_0202);
    tick(1);
    chk("R7 cpu0 unrouted", 32'(irq_valid[0]), 0);
    chk("R7 cpu1 valid", 32'(irq_valid[1]), 1);
    chk("R7 cpu1 id", id_of(1), 33);
    cpu_id = 1;
    rd(7'd64, v); chk("R7 local target read", v, 32'h0202_0202);
    wr(7'd64, 32'hFFFF_FFFF);
    rd(7'd64, v); chk("R7 local target fixed", v, 32'h0202_0202);
    cpu_id = 0;
  endtask

  task automatic test_ctrl();
    wr(7'd0, 32'h0);
    tick(1); chk("R11 forwarding off", 32'(irq_valid), 0);
    wr(7'd0, 32'h1);
    tick(1); chk("R11 forwarding back", 32'(irq_valid[1]), 1);
    @(negedge clk); spi_in[1] = 1'b0; spi_in[2] = 1'b0;
    tick(2); chk("R5 all lines low", 32'(irq_valid), 0);
  endtask

  task automatic test_banked();
    logic [31:0] v;
    cpu_id = 0;
    wr(7'd8, 32'h0001_0000);
    cpu_id = 1;
    rd(7'd8, v); chk("R8 bank1 untouched", v, 0);
    @(negedge clk); ppi_in[0] = 1'b1; ppi_in[16] = 1'b1;
    tick(2);
    chk("R8 cpu0 ppi", 32'(irq_valid[0]), 1);
    chk("R8 cpu0 ppi id", id_of(0), 16);
    chk("R8 cpu1 disabled", 32'(irq_valid[1]), 0);
    ppi_in = '0;
    tick(2);
  endtask

  task automatic test_sgi();
    logic [31:0] v;
    cpu_id = 1;
    wr(7'd8, 32'h20);
    wr(7'd2, 32'h0002_0005);
    tick(1);
    chk("R10 sgi to cpu1", 32'(irq_valid[1]), 1);
    chk("R10 sgi id", id_of(1), 5);
    chk("R10 cpu0 not targeted", 32'(irq_valid[0]), 0);
    rd(7'd16, v); chk("R10 cpu1 pending", v, 32'h20);
    cpu_id = 0;
    rd(7'd16, v); chk("R8 cpu0 pending clear", v, 0);
    cpu_id = 1;
    wr(7'd16, 32'h20);
    tick(1); chk("R10 sgi cleared", 32'(irq_valid[1]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_type();
    test_enable();
    test_config();
    test_level();
    test_edge();
    test_priority();
    test_target();
    test_ctrl();
    test_banked();
    test_sgi();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule